// File: doc/BRIEF.md
# I/O-Aware Cache Way Allocation Controller

This block is the decision core of a shared last-level cache partitioner. Once per sampling epoch it receives, as a one-cycle strobe, the epoch's I/O write-injection counters (hit and miss deltas, the absolute miss count) and the change in cache reference count. It classifies the system into one of five states: quiet I/O at the floor, I/O saturated at the ceiling, I/O-driven pressure, core-driven pressure, and giving capacity back. It moves the number of ways reserved for injected I/O data by at most one per epoch, or it tells a tenant-selection stage to grant or take back one way.

The I/O way count always stays between two programmable bounds. The next stage decides which tenant the grow or shrink command applies to and packs the way masks; this block only issues counts and commands. Every pin is plain control or status, so nothing here stalls and there is no back-pressure. The block evaluates every strobe it receives, and each result is valid for the single cycle in which `upd_valid` is high.

A delta counts as significant when its magnitude is strictly above `thr_stable`. An epoch in which no I/O hit, I/O miss or reference delta is significant is idle. Changes in core throughput that come without any cache or I/O counter change therefore never move the controller; no throughput input exists.

Top module: `ioway_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous reset), the block loads state Low (`ctrl_state`=0), `io_ways`=`cfg_min_ways`, `tenant_cmd`=Hold (0) and `upd_valid`=0. The state codes are Low=0, IoDemand=1, CoreDemand=2, High=3, Reclaim=4. The command codes are Hold=0, Grow=1, Shrink=2.
- R2: An epoch in which |hit|, |miss| and |ref| deltas are all ≤ `thr_stable` leaves `ctrl_state` and `io_ways` unchanged and issues Hold.
- R3: From Low in an active epoch with `miss_count` > `thr_miss_low`, the block goes to CoreDemand with Grow if hits fell (hit delta < −thr) and references rose (ref delta > thr). Otherwise it performs a grow step. With low misses it stays in Low.
- R4: A grow step sets `io_ways` to min(`io_ways`+1, `cfg_max_ways`). The next state is High if the result equals `cfg_max_ways`, and IoDemand otherwise. In IoDemand a grow step occurs each active epoch while misses stay high.
- R5: From IoDemand or High, falling misses (miss delta < −thr) take a reclaim step. Otherwise falling hits go to CoreDemand with Grow. High otherwise holds.
- R6: From CoreDemand, falling misses take a reclaim step. Rising misses without falling hits take a grow step. Anything else stays in CoreDemand and issues Grow.
- R7: A reclaim step with `io_ways` > `cfg_min_ways` decrements `io_ways` and moves to Low if the result is the minimum, and to Reclaim otherwise. With `io_ways` already at the minimum, it issues Shrink and moves to Low. From Reclaim, rising misses go to CoreDemand with Grow if hits fell, and take a grow step otherwise. Anything else takes a reclaim step.
- R8: All outputs are registered. `upd_valid` pulses for exactly the cycle after `epoch_stb`, and `io_ways` and `ctrl_state` change only in that cycle. `tenant_cmd` is Hold whenever `upd_valid` is low.
- R9: With `cfg_min_ways` ≤ `cfg_max_ways` ≤ WAYS−1 held steady, `io_ways` stays within the bounds and changes by at most one per epoch. Low implies `io_ways` = minimum, and High implies `io_ways` = maximum.
- R10: Equal bounds are legal: a grow step from Low goes straight to High, and a reclaim step from High issues Shrink and returns to Low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| epoch_stb | input | 1 | One-cycle strobe: counters below are valid |
| hit_delta | input | CNT_W | Signed change of I/O write-update hits |
| miss_delta | input | CNT_W | Signed change of I/O write-allocate misses |
| ref_delta | input | CNT_W | Signed change of cache references |
| miss_count | input | CNT_W | I/O miss count of this epoch |
| thr_stable | input | CNT_W | Significance threshold for deltas |
| thr_miss_low | input | CNT_W | Miss count above which I/O misses are high |
| cfg_min_ways | input | WAY_W | Floor of the I/O way count |
| cfg_max_ways | input | WAY_W | Ceiling of the I/O way count |
| io_ways | output | WAY_W | Ways granted to injected I/O data |
| tenant_cmd | output | 2 | Hold/Grow/Shrink for the selected tenant |
| upd_valid | output | 1 | Epoch result valid this cycle |
| ctrl_state | output | 3 | Current classification state |

## Verification
A wrong state register shows up at the port within one epoch. `ctrl_state` is visible directly. A wrong state also decides which of the grow, reclaim or Grow-command branches the next active epoch takes, so `io_ways` or `tenant_cmd` then differs from the expected sequence. A corrupted way count breaks the floor and ceiling pairing with Low and High at the same update, or it strays outside the bounds. The bench walks a long pseudo-random series of epochs, covering every mix of rising, falling, flat and insignificant deltas with low and high miss counts, under three bound settings (including equal bounds). It compares all outputs after every strobe and during an idle cycle after it.

// File: rtl/ioway_pkg.sv
package ioway_pkg;
  typedef enum logic [2:0] {
    ST_LOW   = 3'd0,
    ST_IODEM = 3'd1,
    ST_CORE  = 3'd2,
    ST_HIGH  = 3'd3,
    ST_RECL  = 3'd4
  } st_e;

  typedef enum logic [1:0] {
    CMD_HOLD   = 2'd0,
    CMD_GROW   = 2'd1,
    CMD_SHRINK = 2'd2
  } cmd_e;

  typedef struct packed {
    logic active;
    logic miss_high;
    logic miss_rose;
    logic miss_fell;
    logic hit_fell;
    logic ref_rose;
  } cues_t;
endpackage

// File: rtl/ioway_cues.sv
module ioway_cues
  import ioway_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic signed [CNT_W-1:0] hit_d,
  input  logic signed [CNT_W-1:0] miss_d,
  input  logic signed [CNT_W-1:0] ref_d,
  input  logic        [CNT_W-1:0] miss_cnt,
  input  logic        [CNT_W-1:0] thr_stable,
  input  logic        [CNT_W-1:0] thr_miss_low,
  output cues_t                   cues
);
  // one extra bit so the threshold is always positive and its negation fits
  localparam int XW = CNT_W + 1;

  logic signed [XW-1:0] t_pos, t_neg, h_x, m_x, r_x;

  assign t_pos = {1'b0, thr_stable};
  assign t_neg = -t_pos;
  assign h_x   = {hit_d[CNT_W-1], hit_d};
  assign m_x   = {miss_d[CNT_W-1], miss_d};
  assign r_x   = {ref_d[CNT_W-1], ref_d};

  always_comb begin
    cues.hit_fell  = h_x < t_neg;
    cues.miss_rose = m_x > t_pos;
    cues.miss_fell = m_x < t_neg;
    cues.ref_rose  = r_x > t_pos;
    cues.miss_high = miss_cnt > thr_miss_low;
    cues.active    = (h_x > t_pos) || cues.hit_fell ||
                     cues.miss_rose || cues.miss_fell ||
                     cues.ref_rose  || (r_x < t_neg);
  end
endmodule

// File: rtl/ioway_step.sv
module ioway_step
  import ioway_pkg::*;
#(
  parameter int WAY_W = 4
) (
  input  st_e              state,
  input  logic [WAY_W-1:0] io_cur,
  input  logic [WAY_W-1:0] lim_min,
  input  logic [WAY_W-1:0] lim_max,
  input  cues_t            cues,
  output st_e              state_nx,
  output logic [WAY_W-1:0] io_nx,
  output cmd_e             cmd_nx
);
  localparam logic [WAY_W-1:0] ONE = WAY_W'(1);

  logic grow_step, recl_step;

  always_comb begin
    grow_step = 1'b0;
    recl_step = 1'b0;
    state_nx  = state;
    io_nx     = io_cur;
    cmd_nx    = CMD_HOLD;

    if (cues.active) begin
      unique case (state)
        ST_LOW: begin
          if (cues.miss_high) begin
            if (cues.hit_fell && cues.ref_rose) begin
              state_nx = ST_CORE;
              cmd_nx   = CMD_GROW;
            end else begin
              grow_step = 1'b1;
            end
          end
        end
        ST_IODEM, ST_HIGH: begin
          if (cues.miss_fell) begin
            recl_step = 1'b1;
          end else if (cues.hit_fell) begin
            state_nx = ST_CORE;
            cmd_nx   = CMD_GROW;
          end else if (state == ST_IODEM && cues.miss_high) begin
            grow_step = 1'b1;
          end
        end
        ST_CORE: begin
          if (cues.miss_fell) begin
            recl_step = 1'b1;
          end else if (cues.miss_rose && !cues.hit_fell) begin
            grow_step = 1'b1;
          end else begin
            cmd_nx = CMD_GROW;
          end
        end
        ST_RECL: begin
          if (cues.miss_rose) begin
            if (cues.hit_fell) begin
              state_nx = ST_CORE;
              cmd_nx   = CMD_GROW;
            end else begin
              grow_step = 1'b1;
            end
          end else begin
            recl_step = 1'b1;
          end
        end
        default: state_nx = ST_LOW;
      endcase
    end

    if (grow_step) begin
      io_nx    = (io_cur >= lim_max) ? lim_max : io_cur + ONE;
      state_nx = (io_nx == lim_max) ? ST_HIGH : ST_IODEM;
    end

    if (recl_step) begin
      if (io_cur > lim_min) begin
        io_nx    = io_cur - ONE;
        state_nx = (io_nx == lim_min) ? ST_LOW : ST_RECL;
      end else begin
        cmd_nx   = CMD_SHRINK;
        state_nx = ST_LOW;
      end
    end
  end
endmodule

// File: rtl/ioway_ctrl.sv
module ioway_ctrl
  import ioway_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int CNT_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    epoch_stb,
  input  logic signed [CNT_W-1:0] hit_delta,
  input  logic signed [CNT_W-1:0] miss_delta,
  input  logic signed [CNT_W-1:0] ref_delta,
  input  logic        [CNT_W-1:0] miss_count,
  input  logic        [CNT_W-1:0] thr_stable,
  input  logic        [CNT_W-1:0] thr_miss_low,
  input  logic        [WAY_W-1:0] cfg_min_ways,
  input  logic        [WAY_W-1:0] cfg_max_ways,
  output logic        [WAY_W-1:0] io_ways,
  output logic        [1:0]       tenant_cmd,
  output logic                    upd_valid,
  output logic        [2:0]       ctrl_state
);
  cues_t            cues;
  st_e              st_q, st_nx;
  logic [WAY_W-1:0] io_nx;
  cmd_e             cmd_nx;

  ioway_cues #(.CNT_W(CNT_W)) u_cues (
    .hit_d       (hit_delta),
    .miss_d      (miss_delta),
    .ref_d       (ref_delta),
    .miss_cnt    (miss_count),
    .thr_stable  (thr_stable),
    .thr_miss_low(thr_miss_low),
    .cues        (cues)
  );

  ioway_step #(.WAY_W(WAY_W)) u_step (
    .state   (st_q),
    .io_cur  (io_ways),
    .lim_min (cfg_min_ways),
    .lim_max (cfg_max_ways),
    .cues    (cues),
    .state_nx(st_nx),
    .io_nx   (io_nx),
    .cmd_nx  (cmd_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_LOW;
      io_ways    <= cfg_min_ways;
      tenant_cmd <= CMD_HOLD;
      upd_valid  <= 1'b0;
    end else begin
      upd_valid  <= epoch_stb;
      tenant_cmd <= epoch_stb ? cmd_nx : CMD_HOLD;
      if (epoch_stb) begin
        st_q    <= st_nx;
        io_ways <= io_nx;
      end
    end
  end

  assign ctrl_state = st_q;

  // R8
  no_move_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(epoch_stb) |-> ($stable(io_ways) && $stable(ctrl_state) && !upd_valid));
  // R8
  cmd_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tenant_cmd != CMD_HOLD) |-> upd_valid);
  // R9
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_ways == $past(io_ways)) || (io_ways == $past(io_ways) + WAY_W'(1)) ||
    (io_ways + WAY_W'(1) == $past(io_ways)));
  // R9
  in_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_ways >= cfg_min_ways) && (io_ways <= cfg_max_ways));
  // R9
  low_at_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_LOW) |-> (io_ways == cfg_min_ways));
  // R9
  high_at_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HIGH) |-> (io_ways == cfg_max_ways));
endmodule

// File: tb/ioway_ctrl_bench.sv
module ioway_ctrl_bench;
  localparam int WAYS  = 16;
  localparam int CNT_W = 16;
  localparam int WAY_W = 4;
  localparam int THR   = 10;
  localparam int MLOW  = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic epoch_stb = 1'b0;
  logic signed [CNT_W-1:0] hit_delta = '0, miss_delta = '0, ref_delta = '0;
  logic [CNT_W-1:0] miss_count = '0;
  logic [CNT_W-1:0] thr_stable = CNT_W'(THR);
  logic [CNT_W-1:0] thr_miss_low = CNT_W'(MLOW);
  logic [WAY_W-1:0] cfg_min_ways = 4'd1, cfg_max_ways = 4'd4;
  logic [WAY_W-1:0] io_ways;
  logic [1:0] tenant_cmd;
  logic upd_valid;
  logic [2:0] ctrl_state;

  int checks = 0;
  int errors = 0;
  int m_st, m_io, m_cmd, lo, hi;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  ioway_ctrl #(.WAYS(WAYS), .CNT_W(CNT_W)) u_ioway_ctrl (
    .clk(clk), .rst_n(rst_n), .epoch_stb(epoch_stb),
    .hit_delta(hit_delta), .miss_delta(miss_delta), .ref_delta(ref_delta),
    .miss_count(miss_count), .thr_stable(thr_stable), .thr_miss_low(thr_miss_low),
    .cfg_min_ways(cfg_min_ways), .cfg_max_ways(cfg_max_ways),
    .io_ways(io_ways), .tenant_cmd(tenant_cmd), .upd_valid(upd_valid),
    .ctrl_state(ctrl_state)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model built from the requirements
  task automatic model(input int h, input int m, input int r, input int mc);
    bit act, mhigh, mrose, mfell, hfell, rrose, grow, recl;
    act   = (h > THR) || (h < -THR) || (m > THR) || (m < -THR) || (r > THR) || (r < -THR);
    mhigh = mc > MLOW;
    mrose = m > THR;
    mfell = m < -THR;
    hfell = h < -THR;
    rrose = r > THR;
    grow = 0; recl = 0; m_cmd = 0;
    if (act) begin
      case (m_st)
        0: if (mhigh) begin
             if (hfell && rrose) begin m_st = 2; m_cmd = 1; end else grow = 1;
           end
        1, 3: if (mfell) recl = 1;
              else if (hfell) begin m_st = 2; m_cmd = 1; end
              else if (m_st == 1 && mhigh) grow = 1;
        2: if (mfell) recl = 1;
           else if (mrose && !hfell) grow = 1;
           else m_cmd = 1;
        default: if (mrose) begin
                   if (hfell) begin m_st = 2; m_cmd = 1; end else grow = 1;
                 end else recl = 1;
      endcase
    end
    if (grow) begin
      m_io = (m_io >= hi) ? hi : m_io + 1;
      m_st = (m_io == hi) ? 3 : 1;
    end
    if (recl) begin
      if (m_io > lo) begin
        m_io = m_io - 1;
        m_st = (m_io == lo) ? 0 : 4;
      end else begin
        m_cmd = 2;
        m_st = 0;
      end
    end
  endtask

  task automatic do_reset(input int mn, input int mx);
    @(negedge clk);
    rst_n = 1'b0;
    cfg_min_ways = WAY_W'(mn);
    cfg_max_ways = WAY_W'(mx);
    lo = mn; hi = mx;
    m_st = 0; m_io = mn; m_cmd = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "state", int'(ctrl_state), 0);
    chk("R1", "io_ways", int'(io_ways), mn);
    chk("R1", "cmd", int'(tenant_cmd), 0);
    chk("R1", "valid", int'(upd_valid), 0);
  endtask

  // one epoch: drive at negedge, strobe one cycle, compare next negedge
  task automatic epoch(input int h, input int m, input int r, input int mc,
                       input bit idle_after, input string tag_in);
    string tag;
    string tags [5] = '{"R3", "R4", "R6", "R5", "R7"};
    bit act;
    act = (h > THR) || (h < -THR) || (m > THR) || (m < -THR) || (r > THR) || (r < -THR);
    tag = (tag_in != "") ? tag_in : (act ? tags[m_st] : "R2");
    hit_delta  = CNT_W'(h);
    miss_delta = CNT_W'(m);
    ref_delta  = CNT_W'(r);
    miss_count = CNT_W'(mc);
    epoch_stb  = 1'b1;
    model(h, m, r, mc);
    @(negedge clk);
    epoch_stb = 1'b0;
    chk("R8", "valid pulse", int'(upd_valid), 1);
    chk(tag, "state", int'(ctrl_state), m_st);
    chk(tag, "io_ways", int'(io_ways), m_io);
    chk(tag, "cmd", int'(tenant_cmd), m_cmd);
    chk("R9", "io in bounds", int'(io_ways >= WAY_W'(lo) && io_ways <= WAY_W'(hi)), 1);
    if (idle_after) begin
      hit_delta = CNT_W'(-500);
      miss_delta = CNT_W'(500);
      miss_count = CNT_W'(900);
      @(negedge clk);
      chk("R8", "idle valid", int'(upd_valid), 0);
      chk("R8", "idle cmd", int'(tenant_cmd), 0);
      chk("R8", "idle io", int'(io_ways), m_io);
      chk("R8", "idle state", int'(ctrl_state), m_st);
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vals [4] = '{-50, 0, 50, 5};
    int mcs [2] = '{20, 300};
    int cfg_lo [3] = '{1, 2, 0};
    int cfg_hi [3] = '{4, 2, 15};

    // directed walk with bounds 1..4
    do_reset(1, 4);
    epoch(5, -5, 5, 300, 1, "R2");        // idle epoch, misses high but no significant delta
    epoch(50, 50, 0, 20, 0, "R3");        // low misses: stay in Low
    epoch(50, 50, 0, 300, 0, "R3");       // -> IoDemand, io 2
    epoch(0, 50, 0, 300, 0, "R4");        // io 3
    epoch(0, 50, 0, 300, 1, "R4");        // io 4 -> High
    epoch(-50, 0, 0, 300, 0, "R5");       // High, hits fell -> CoreDemand + Grow
    epoch(0, 0, 50, 300, 0, "R6");        // stay CoreDemand + Grow
    epoch(0, -50, 0, 20, 0, "R6");        // misses fell -> reclaim io 3
    epoch(0, 0, 50, 20, 0, "R7");         // io 2
    epoch(-50, 50, 0, 300, 0, "R7");      // misses rose, hits fell -> CoreDemand
    epoch(0, -50, 0, 20, 0, "R7");        // reclaim io 1 -> Low
    epoch(-50, 50, 50, 300, 0, "R3");     // Low -> CoreDemand
    epoch(0, -50, 0, 20, 0, "R7");        // reclaim at floor -> Shrink, Low

    // equal bounds
    do_reset(2, 2);
    epoch(50, 50, 0, 300, 0, "R10");      // straight to High
    epoch(0, -50, 0, 20, 0, "R10");       // Shrink, back to Low

    // pseudo-random sweep over all stimulus classes, three bound settings
    for (int c = 0; c < 3; c++) begin
      do_reset(cfg_lo[c], cfg_hi[c]);
      for (int n = 0; n < 600; n++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        epoch(vals[seed[17:16]], vals[seed[19:18]], vals[seed[21:20]],
              mcs[seed[22]], seed[25:23] == 3'd0, "");
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule